// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast-Vector Matching

This block collects a set of interrupt request lines and picks one request to hand to the processor core. Each source has a 2-bit priority field, and the value zero disables that source. The core supplies a 2-bit mask level. A request is offered only when its level is at or above that mask. The winning request is turned into a vector address. Normally this address is the programmed base with the vector number placed below it. Two match registers let a level-2 source skip the table and jump straight to a fully programmed 21-bit address.

The chosen vector stays on the outputs, flagged valid, until the core acknowledges it. Nesting follows from the mask. On entry to a handler the core raises its mask, so only higher levels can interrupt that handler. Once the mask is lowered again, waiting lower-level requests come through.

A wake output serves the low-power modes. It uses the set of sources that were enabled at the moment low-power mode began.

Top module: `intc_top`

## Requirements
- R1: After reset, vecValid and wakeOut are low, every priority field reads 0, the base and address registers read 0, and both match registers read 0x00FF.
- R2: Source i takes its priority from register i/8, bits [2*(i%8)+1 : 2*(i%8)]. A field value of 0 means the source is never presented, even when its request is pending.
- R3: A request at level L (1 to 3) can be presented only if L is at least maskLevel. Mask 0 lets levels 1 to 3 through, mask 1 lets 1 to 3 through, mask 2 lets 2 and 3 through, and mask 3 lets only level 3 through.
- R4: Among pending, enabled, permitted requests, the highest level wins. When levels are equal, the lowest source number wins.
- R5: The normal vector address is {base[11:0], vecNum[7:0], 1'b0}, and vecFast is 0.
- R6: A winner at level 2 whose number equals match register 0 gets the address {hi0[4:0], lo0[15:0]}. If instead it equals match register 1, it gets {hi1, lo1}. In both cases vecFast is 1. When both match registers hold the winner's number, match register 0 wins. A matching winner at any level other than 2 gets the normal address.
- R7: While vecValid is high and ackIn is low, vecNum, vecAddr and vecFast do not change, even if a higher request arrives. A sampled ackIn drops vecValid on that edge.
- R8: Sources 0 to 7 are edge sources. A rising edge latches the request, and an acknowledge of that vector clears it. Sources 8 to 15 are level sources. They are pending while their input is high and are presented again after an acknowledge for as long as the input stays high.
- R9: After an acknowledge, if the core raises maskLevel, only higher-level requests are presented. Lower ones wait and are presented once the mask is lowered.
- R10: wakeOut is high when lowPower is high and a pending source was enabled on the cycle before lowPower rose. A source enabled after that point does not cause a wake. wakeOut ignores maskLevel.
- R11: Register map on regAddr: 0 to 1 hold the priority fields, 8 holds the base (12 bits), 9 and 10 hold match registers 0 and 1 (8 bits each), 11 and 12 hold address pair 0 low (16 bits) and high (5 bits), and 13 and 14 hold pair 1. Reads return the stored bits, and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Request lines, one per source |
| maskLevel | input | 2 | Core interrupt mask level |
| lowPower | input | 1 | High while the core is in wait or stop |
| ackIn | input | 1 | Core accepts the presented vector |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register select |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| vecValid | output | 1 | A vector is presented |
| vecNum | output | 8 | Presented vector number |
| vecAddr | output | 21 | Presented vector address |
| vecFast | output | 1 | Address came from a fast match pair |
| wakeOut | output | 1 | Wake request during low-power mode |

## Verification
Two functions can meet on the same edge. One is an acknowledge that clears a pending edge request and drops the valid flag. The other is the arbiter seeing a new request or a changed mask. The bench acknowledges from its monitor on the cycle after each vector appears. Meanwhile the driver fires several sources in one cycle, or raises the mask right after an acknowledge, to mimic a core entering a nested handler. Every vector that appears is matched against a queue of expected numbers, addresses and fast flags in the required order, and any surplus presentation counts as a failure. This shows both that each acknowledged edge request is cleared exactly once and that the held vector never changes under a later arrival.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] RA_BASE  = 4'd8;
  localparam logic [REG_AW-1:0] RA_FM0   = 4'd9;
  localparam logic [REG_AW-1:0] RA_FM1   = 4'd10;
  localparam logic [REG_AW-1:0] RA_FA0LO = 4'd11;
  localparam logic [REG_AW-1:0] RA_FA0HI = 4'd12;
  localparam logic [REG_AW-1:0] RA_FA1LO = 4'd13;
  localparam logic [REG_AW-1:0] RA_FA1HI = 4'd14;

  // strobes from control to datapath
  typedef struct packed {
    logic loadVec;
    logic ackTake;
  } ctrlStrb_t;
endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int VEC_W   = 8,
  parameter int BASE_W  = 12,
  parameter int LO_W    = 16,
  parameter int HI_W    = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [15:0]             regWrData,
  output logic [15:0]             regRdData,
  output logic [2*NUM_SRC-1:0]    priFlat,
  output logic [BASE_W-1:0]       baseReg,
  output logic [VEC_W-1:0]        fm0,
  output logic [VEC_W-1:0]        fm1,
  output logic [HI_W+LO_W-1:0]    fa0,
  output logic [HI_W+LO_W-1:0]    fa1
);
  localparam int NPRI = (2*NUM_SRC + 15) / 16;

  logic [15:0]     priReg [NPRI];
  logic [LO_W-1:0] fa0Lo, fa1Lo;
  logic [HI_W-1:0] fa0Hi, fa1Hi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NPRI; p++) priReg[p] <= '0;
      baseReg <= '0;
      fm0     <= '1;
      fm1     <= '1;
      fa0Lo   <= '0;
      fa0Hi   <= '0;
      fa1Lo   <= '0;
      fa1Hi   <= '0;
    end else if (regWrEn) begin
      for (int p = 0; p < NPRI; p++)
        if (regAddr == REG_AW'(p)) priReg[p] <= regWrData;
      case (regAddr)
        RA_BASE:  baseReg <= regWrData[BASE_W-1:0];
        RA_FM0:   fm0     <= regWrData[VEC_W-1:0];
        RA_FM1:   fm1     <= regWrData[VEC_W-1:0];
        RA_FA0LO: fa0Lo   <= regWrData[LO_W-1:0];
        RA_FA0HI: fa0Hi   <= regWrData[HI_W-1:0];
        RA_FA1LO: fa1Lo   <= regWrData[LO_W-1:0];
        RA_FA1HI: fa1Hi   <= regWrData[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    for (int p = 0; p < NPRI; p++)
      if (regAddr == REG_AW'(p)) regRdData = priReg[p];
    case (regAddr)
      RA_BASE:  regRdData = 16'(baseReg);
      RA_FM0:   regRdData = 16'(fm0);
      RA_FM1:   regRdData = 16'(fm1);
      RA_FA0LO: regRdData = 16'(fa0Lo);
      RA_FA0HI: regRdData = 16'(fa0Hi);
      RA_FA1LO: regRdData = 16'(fa1Lo);
      RA_FA1HI: regRdData = 16'(fa1Hi);
      default: ;
    endcase
  end

  // eight 2-bit fields per 16-bit priority register
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
    assign priFlat[2*i +: 2] = priReg[i/8][2*(i%8) +: 2];
  end

  assign fa0 = {fa0Hi, fa0Lo};
  assign fa1 = {fa1Hi, fa1Lo};
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter int                 VEC_W    = 8,
  parameter int                 ADDR_W   = 21,
  parameter int                 BASE_W   = 12,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 16'h00FF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqIn,
  input  logic [1:0]           maskLevel,
  input  logic                 lowPower,
  input  ctrlStrb_t            strb,
  input  logic [2*NUM_SRC-1:0] priFlat,
  input  logic [BASE_W-1:0]    baseReg,
  input  logic [VEC_W-1:0]     fm0,
  input  logic [VEC_W-1:0]     fm1,
  input  logic [ADDR_W-1:0]    fa0,
  input  logic [ADDR_W-1:0]    fa1,
  output logic                 anyWin,
  output logic [VEC_W-1:0]     vecNumQ,
  output logic [ADDR_W-1:0]    vecAddrQ,
  output logic                 vecFastQ,
  output logic                 wakeOut
);
  localparam int SRC_IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] irqPrev, pend, pendNext, enabledVec, enSnap;
  logic [VEC_W-1:0]   winIdx;
  logic [1:0]         winLvl, vecLvlQ;
  logic               hit0, hit1;
  logic [ADDR_W-1:0]  nextAddr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign enabledVec[g] = (priFlat[2*g +: 2] != 2'd0);
    if (EDGE_SRC[g]) begin : g_edge
      assign pendNext[g] = (irqIn[g] & ~irqPrev[g]) |
                           (pend[g] & ~(strb.ackTake && vecNumQ == VEC_W'(g)));
    end else begin : g_level
      assign pendNext[g] = irqIn[g];
    end
  end

  // highest level wins; scanning downward keeps the lowest index on a tie
  always_comb begin
    logic [1:0] lvl;
    winLvl = 2'd0;
    winIdx = '0;
    anyWin = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      lvl = priFlat[2*i +: 2];
      if (pend[i] && lvl != 2'd0 && lvl >= maskLevel && lvl >= winLvl) begin
        winLvl = lvl;
        winIdx = VEC_W'(i);
        anyWin = 1'b1;
      end
    end
  end

  assign hit0 = (winLvl == 2'd2) && (winIdx == fm0);
  assign hit1 = (winLvl == 2'd2) && (winIdx == fm1);
  assign nextAddr = hit0 ? fa0 : (hit1 ? fa1 : {baseReg, winIdx, 1'b0});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= '0;
      pend     <= '0;
      enSnap   <= '0;
      vecNumQ  <= '0;
      vecAddrQ <= '0;
      vecFastQ <= 1'b0;
      vecLvlQ  <= 2'd0;
    end else begin
      irqPrev <= irqIn;
      pend    <= pendNext;
      if (!lowPower) enSnap <= enabledVec;
      if (strb.loadVec) begin
        vecNumQ  <= winIdx;
        vecAddrQ <= nextAddr;
        vecFastQ <= hit0 | hit1;
        vecLvlQ  <= winLvl;
      end
    end
  end

  assign wakeOut = lowPower & |(pend & enSnap);

  assert_load_permitted_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadVec |=> (vecLvlQ != 2'd0 && vecLvlQ >= $past(maskLevel)));

  assert_normal_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadVec && winLvl != 2'd2) |=>
      (vecAddrQ == {$past(baseReg), vecNumQ, 1'b0} && !vecFastQ));

  assert_fast0_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadVec && winLvl == 2'd2 && winIdx == fm0) |=>
      (vecAddrQ == $past(fa0) && vecFastQ));

  assert_edge_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackTake && EDGE_SRC[vecNumQ[SRC_IW-1:0]] && !irqIn[vecNumQ[SRC_IW-1:0]])
      |=> !pend[$past(vecNumQ[SRC_IW-1:0])]);
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyWin,
  input  logic      ackIn,
  output logic      vecValid,
  output ctrlStrb_t strb
);
  assign strb.loadVec = !vecValid && anyWin;
  assign strb.ackTake = vecValid && ackIn;

  always_ff @(posedge clk) begin
    if (!rstN)             vecValid <= 1'b0;
    else if (strb.loadVec) vecValid <= 1'b1;
    else if (strb.ackTake) vecValid <= 1'b0;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC  = 16,
  parameter int                 VEC_W    = 8,
  parameter int                 ADDR_W   = 21,
  parameter int                 LO_W     = 16,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 16'h00FF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [1:0]         maskLevel,
  input  logic               lowPower,
  input  logic               ackIn,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [15:0]        regWrData,
  output logic [15:0]        regRdData,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecNum,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               vecFast,
  output logic               wakeOut
);
  localparam int HI_W   = ADDR_W - LO_W;
  localparam int BASE_W = ADDR_W - VEC_W - 1;

  ctrlStrb_t            strb;
  logic [2*NUM_SRC-1:0] priFlat;
  logic [BASE_W-1:0]    baseReg;
  logic [VEC_W-1:0]     fm0, fm1;
  logic [ADDR_W-1:0]    fa0, fa1;
  logic                 anyWin;

  intc_regfile #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .BASE_W(BASE_W),
                 .LO_W(LO_W), .HI_W(HI_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .priFlat(priFlat),
    .baseReg(baseReg), .fm0(fm0), .fm1(fm1), .fa0(fa0), .fa1(fa1));

  intc_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
                  .BASE_W(BASE_W), .EDGE_SRC(EDGE_SRC)) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskLevel(maskLevel),
    .lowPower(lowPower), .strb(strb), .priFlat(priFlat), .baseReg(baseReg),
    .fm0(fm0), .fm1(fm1), .fa0(fa0), .fa1(fa1), .anyWin(anyWin),
    .vecNumQ(vecNum), .vecAddrQ(vecAddr), .vecFastQ(vecFast),
    .wakeOut(wakeOut));

  intc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .anyWin(anyWin), .ackIn(ackIn),
    .vecValid(vecValid), .strb(strb));

  assert_hold_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !ackIn) |=>
      (vecValid && $stable(vecNum) && $stable(vecAddr) && $stable(vecFast)));
endmodule

// File: tb/intc_top_tb_top.sv
`timescale 1ns/1ps
module intc_top_tb_top;
  typedef struct packed {
    logic [7:0]  num;
    logic [20:0] addr;
    logic        fast;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [1:0]  maskLevel = 2'd0;
  logic        lowPower = 1'b0;
  logic        ackIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        vecValid, vecFast, wakeOut;
  logic [7:0]  vecNum;
  logic [20:0] vecAddr;

  int   checks = 0;
  int   failures = 0;
  bit   monOn = 1'b0;
  bit   finished = 1'b0;
  exp_t expQ[$];
  logic [15:0] priShadow [2];
  logic [11:0] baseShadow = '0;

  always #2.5 clk = ~clk;

  intc_top dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskLevel(maskLevel),
    .lowPower(lowPower), .ackIn(ackIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .vecValid(vecValid),
    .vecNum(vecNum), .vecAddr(vecAddr), .vecFast(vecFast), .wakeOut(wakeOut));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: compare each presented vector with the scoreboard, then acknowledge
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (ackIn) ackIn = 1'b0;
      else if (vecValid) begin
        if (expQ.size() == 0) begin
          chk("R4", "unexpected vector", 32'(vecNum), 32'hFFFF);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk("R4", "vector number", 32'(vecNum), 32'(e.num));
          chk("R5", "vector address", 32'(vecAddr), 32'(e.addr));
          chk("R6", "fast flag", 32'(vecFast), 32'(e.fast));
        end
        ackIn = 1'b1;
      end
    end
  end

  function automatic logic [20:0] normAddr(input logic [7:0] n);
    return {baseShadow, n, 1'b0};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRdChk(input logic [3:0] a, input logic [15:0] expv, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(req, "register read", 32'(regRdData), 32'(expv));
  endtask

  task automatic setPri(input int src, input logic [1:0] lvl);
    priShadow[src/8][2*(src%8) +: 2] = lvl;
    regWr(4'(src/8), priShadow[src/8]);
  endtask

  task automatic pushNorm(input logic [7:0] n);
    expQ.push_back('{num: n, addr: normAddr(n), fast: 1'b0});
  endtask

  task automatic fire(input logic [15:0] m);
    @(negedge clk);
    irqIn = irqIn | m;
    @(negedge clk);
    irqIn = irqIn & ~m;
  endtask

  task automatic drain(input string req);
    for (int n = 0; n < 200 && (expQ.size() != 0 || vecValid || ackIn); n++)
      @(negedge clk);
    chk(req, "scoreboard drained", 32'(expQ.size()), 32'd0);
    cyc(3);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    cyc(150000);
    failures++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    priShadow[0] = '0;
    priShadow[1] = '0;
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1", "vecValid after reset", 32'(vecValid), 32'd0);
    chk("R1", "wakeOut after reset", 32'(wakeOut), 32'd0);
    regRdChk(4'd0, 16'h0000, "R1");
    regRdChk(4'd9, 16'h00FF, "R1");
    regRdChk(4'd14, 16'h0000, "R1");

    // R11 register map and unused bits
    regWr(4'd8, 16'hF123); baseShadow = 12'h123;
    regRdChk(4'd8, 16'h0123, "R11");
    regWr(4'd12, 16'hFFF1);
    regRdChk(4'd12, 16'h0011, "R11");
    regWr(4'd10, 16'h1205);
    regRdChk(4'd10, 16'h0005, "R11");
    regWr(4'd9, 16'h0003);
    regWr(4'd11, 16'h4000);
    regWr(4'd13, 16'hBEEF);
    regWr(4'd14, 16'h000A);
    regRdChk(4'd13, 16'hBEEF, "R11");
    monOn = 1'b1;

    // R2 disabled source never presented
    fire(16'h0002);
    cyc(6);
    chk("R2", "disabled source presented", 32'(vecValid), 32'd0);
    setPri(9, 2'd3);
    regRdChk(4'd1, 16'h000C, "R2");
    setPri(9, 2'd0);

    // R5 normal address
    setPri(0, 2'd1);
    pushNorm(8'd0);
    fire(16'h0001);
    drain("R5");

    // R4 level then lowest number; R8 edge requests cleared once each
    setPri(2, 2'd1); setPri(4, 2'd3); setPri(6, 2'd3);
    pushNorm(8'd4); pushNorm(8'd6); pushNorm(8'd2);
    fire(16'h0054);
    drain("R4");
    cyc(4);
    chk("R8", "edge request re-presented", 32'(vecValid), 32'd0);

    // R3 mask thresholds
    maskLevel = 2'd2;
    fire(16'h0004);
    cyc(6);
    chk("R3", "level 1 under mask 2", 32'(vecValid), 32'd0);
    pushNorm(8'd2);
    maskLevel = 2'd0;
    drain("R3");
    maskLevel = 2'd3;
    pushNorm(8'd4);
    fire(16'h0010);
    drain("R3");
    maskLevel = 2'd0;

    // R6 fast matches
    setPri(3, 2'd2);
    expQ.push_back('{num: 8'd3, addr: 21'h114000, fast: 1'b1});
    fire(16'h0008);
    drain("R6");
    setPri(5, 2'd2);
    expQ.push_back('{num: 8'd5, addr: {5'h0A, 16'hBEEF}, fast: 1'b1});
    fire(16'h0020);
    drain("R6");
    setPri(5, 2'd1);
    pushNorm(8'd5);
    fire(16'h0020);
    drain("R6");
    regWr(4'd9, 16'h0007);
    regWr(4'd10, 16'h0007);
    setPri(7, 2'd2);
    expQ.push_back('{num: 8'd7, addr: 21'h114000, fast: 1'b1});
    fire(16'h0080);
    drain("R6");

    // R9 nesting through a raised mask
    pushNorm(8'd0);
    fire(16'h0001);
    drain("R9");
    maskLevel = 2'd2;
    pushNorm(8'd4);
    fire(16'h0014);
    drain("R9");
    chk("R9", "lower request while nested", 32'(vecValid), 32'd0);
    pushNorm(8'd2);
    maskLevel = 2'd0;
    drain("R9");

    // R7 hold until acknowledge
    monOn = 1'b0;
    fire(16'h0004);
    cyc(3);
    chk("R7", "held vector valid", 32'(vecValid), 32'd1);
    fire(16'h0010);
    cyc(3);
    chk("R7", "held number under higher arrival", 32'(vecNum), 32'd2);
    chk("R7", "held address", 32'(vecAddr), 32'(normAddr(8'd2)));
    pushNorm(8'd2); pushNorm(8'd4);
    monOn = 1'b1;
    drain("R7");

    // R8 level source
    monOn = 1'b0;
    setPri(8, 2'd2);
    @(negedge clk); irqIn[8] = 1'b1;
    cyc(3);
    chk("R8", "level source number", 32'(vecNum), 32'd8);
    chk("R8", "level source address", 32'(vecAddr), 32'(normAddr(8'd8)));
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
    cyc(2);
    chk("R8", "level source re-presented", 32'(vecValid), 32'd1);
    irqIn[8] = 1'b0;
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
    cyc(3);
    chk("R8", "level source released", 32'(vecValid), 32'd0);
    monOn = 1'b1;

    // R10 wake uses enables captured before low power
    setPri(6, 2'd1);
    setPri(5, 2'd0);
    maskLevel = 2'd3;
    cyc(1);
    lowPower = 1'b1;
    cyc(2);
    setPri(5, 2'd1);
    fire(16'h0020);
    cyc(3);
    chk("R10", "wake from late-enabled source", 32'(wakeOut), 32'd0);
    fire(16'h0040);
    cyc(2);
    chk("R10", "wake under mask 3", 32'(wakeOut), 32'd1);
    chk("R10", "no vector under mask 3", 32'(vecValid), 32'd0);
    @(negedge clk); lowPower = 1'b0;
    #1;
    chk("R10", "wake after low power exit", 32'(wakeOut), 32'd0);
    pushNorm(8'd5); pushNorm(8'd6);
    maskLevel = 2'd0;
    drain("R10");

    finish();
  end
endmodule